// File: doc/BRIEF.md
# FDL Loopback Code Detector

This block sits behind a facility-data-link decoder that has already pulled the 6-bit unscheduled-message codewords out of the link bit stream. Each codeword arrives with a one-cycle valid strobe. The detector confirms a codeword only after it has seen the same value three times in a row. It then reports the confirmed value in a receive register that clears when read, and it pulls an active-low interrupt.

Confirmed activate and deactivate codes drive two loopback outputs, one for payload loopback and one for line loopback. Each output has its own code pair. A small control register can force either output to a fixed level. An alternate operating-mode input keeps the line-loopback output inactive.

Top module: `fdl_lb_detect`

## Requirements
- R1: A codeword is confirmed on the third valid reception of the same value in a row. Cycles with the valid strobe low do not break the run.
- R2: A valid codeword that differs from the previous valid codeword restarts the repetition count at one for the new value.
- R3: After a confirmation, further repeats of the same codeword do not confirm again until a different codeword has arrived.
- R4: The receive register shows the confirmed code in bits 5:0, and bits 7:6 are always 0. A read strobe clears the register to 00h at that clock edge. If a confirmation occurs in the same cycle as a read, the new code is loaded.
- R5: irq_no goes low at the confirming edge. It stays low until the receive register is read, unless that read coincides with a new confirmation.
- R6: plb_o rises on a confirmed 001010. It falls on a confirmed 011001.
- R7: llb_o rises on a confirmed 000111. It falls on a confirmed 011100.
- R8: The control register is written with ctrl_wr_i, and its bits have these meanings:
  - bit 0 set forces plb_o to the value of bit 1.
  - bit 2 set forces llb_o to the value of bit 3.
  - While a force is active, the loopback state underneath still follows confirmed codes, and that state shows again once the force is released.
- R9: While alt_mode_i is high, llb_o is low even when forced high, and a line-loopback activate code has no effect. The line-loopback state is cleared, so llb_o remains low after alt_mode_i falls. Codewords are still confirmed and reported.
- R10: Reset has the following effect:
  - irq_no goes high.
  - The receive register is cleared to 00h.
  - Both loopback outputs go low.
  - The control register is cleared to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 6 | Received unscheduled-message codeword |
| code_valid_i | input | 1 | code_i is valid this cycle |
| alt_mode_i | input | 1 | Alternate operating mode; holds line loopback inactive |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| ctrl_data_i | input | 4 | Control data: {ll_val, ll_en, pl_val, pl_en} |
| rx_rd_i | input | 1 | Read of the receive register (clears it) |
| rx_code_o | output | 8 | Receive register: confirmed code in bits 5:0 |
| irq_no | output | 1 | Interrupt, active low |
| plb_o | output | 1 | Payload-loopback output |
| llb_o | output | 1 | Line-loopback output |

## Verification
Every result is due at the clock edge that samples its cause, with no extra pipeline stage:
- A confirmation, a read clear or a control write shows on the outputs right after that edge.
- A change of alt_mode_i reaches llb_o combinationally.

The bench drives inputs two time units after a rising edge and samples two time units after the next one, so each check sees exactly one edge's worth of effect. Coincident read-and-confirm and runs broken by invalid cycles are placed in the vector table at known steps.

// File: rtl/fdl_lb_pkg.sv
package fdl_lb_pkg;
  localparam int CODE_W = 6;
  localparam int REG_W  = 8;
  localparam int N_LB   = 2;  // 0: payload, 1: line

  localparam logic [CODE_W-1:0] PL_ON  = 6'b001010;
  localparam logic [CODE_W-1:0] PL_OFF = 6'b011001;
  localparam logic [CODE_W-1:0] LL_ON  = 6'b000111;
  localparam logic [CODE_W-1:0] LL_OFF = 6'b011100;

  localparam logic [N_LB-1:0][CODE_W-1:0] LB_ON  = {LL_ON, PL_ON};
  localparam logic [N_LB-1:0][CODE_W-1:0] LB_OFF = {LL_OFF, PL_OFF};

  typedef struct packed {
    logic ll_val;
    logic ll_en;
    logic pl_val;
    logic pl_en;
  } lb_ctrl_t;
endpackage

// File: rtl/fdl_lb_confirm.sv
module fdl_lb_confirm #(
  parameter int CODE_W   = 6,
  parameter int REPEAT_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              valid_i,
  output logic              hit_o
);
  localparam int CNT_W = $clog2(REPEAT_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REPEAT_N);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CODE_W-1:0] last_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              same;

  assign same  = (cnt_q != '0) && (code_i == last_q);
  assign cnt_d = !same ? CNT_ONE : (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
  // fire once when the run reaches the limit, never while saturated
  assign hit_o = valid_i && (cnt_d == CNT_MAX) && !(same && cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (valid_i) begin
      last_q <= code_i;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/fdl_lb_latch.sv
module fdl_lb_latch #(
  parameter int                CODE_W  = 6,
  parameter logic [CODE_W-1:0] ON_CODE  = '0,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              inhibit_i,
  input  logic              ovr_en_i,
  input  logic              ovr_val_i,
  output logic              state_o,
  output logic              lb_o
);
  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          state_q <= 1'b0;
    else if (inhibit_i)                   state_q <= 1'b0;
    else if (hit_i && code_i == ON_CODE)  state_q <= 1'b1;
    else if (hit_i && code_i == OFF_CODE) state_q <= 1'b0;
  end

  assign state_o = state_q;
  assign lb_o    = !inhibit_i && (ovr_en_i ? ovr_val_i : state_q);
endmodule

// File: rtl/fdl_lb_rxreg.sv
module fdl_lb_rxreg #(
  parameter int CODE_W = 6,
  parameter int REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rd_i,
  output logic [REG_W-1:0]  rx_o,
  output logic              irq_no
);
  logic [CODE_W-1:0] rx_q;
  logic              irq_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      irq_nq <= 1'b1;
    end else if (hit_i) begin
      rx_q   <= code_i;
      irq_nq <= 1'b0;
    end else if (rd_i) begin
      rx_q   <= '0;
      irq_nq <= 1'b1;
    end
  end

  assign rx_o   = REG_W'(rx_q);
  assign irq_no = irq_nq;
endmodule

// File: rtl/fdl_lb_detect.sv
module fdl_lb_detect
  import fdl_lb_pkg::*;
#(
  parameter int REPEAT_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_valid_i,
  input  logic              alt_mode_i,
  input  logic              ctrl_wr_i,
  input  logic [3:0]        ctrl_data_i,
  input  logic              rx_rd_i,
  output logic [REG_W-1:0]  rx_code_o,
  output logic              irq_no,
  output logic              plb_o,
  output logic              llb_o
);
  lb_ctrl_t        ctrl_q;
  logic            hit_w;
  logic [N_LB-1:0] lb_w, st_w, ovr_en_w, ovr_val_w, inh_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= lb_ctrl_t'(ctrl_data_i);
  end

  fdl_lb_confirm #(.CODE_W(CODE_W), .REPEAT_N(REPEAT_N)) u_conf (
    .clk_i, .rst_ni, .code_i, .valid_i(code_valid_i), .hit_o(hit_w)
  );

  fdl_lb_rxreg #(.CODE_W(CODE_W), .REG_W(REG_W)) u_rx (
    .clk_i, .rst_ni, .hit_i(hit_w), .code_i, .rd_i(rx_rd_i),
    .rx_o(rx_code_o), .irq_no
  );

  assign ovr_en_w  = {ctrl_q.ll_en,  ctrl_q.pl_en};
  assign ovr_val_w = {ctrl_q.ll_val, ctrl_q.pl_val};
  assign inh_w     = {alt_mode_i, 1'b0};

  for (genvar i = 0; i < N_LB; i++) begin : g_lb
    fdl_lb_latch #(.CODE_W(CODE_W), .ON_CODE(LB_ON[i]), .OFF_CODE(LB_OFF[i])) u_lb (
      .clk_i, .rst_ni, .hit_i(hit_w), .code_i, .inhibit_i(inh_w[i]),
      .ovr_en_i(ovr_en_w[i]), .ovr_val_i(ovr_val_w[i]),
      .state_o(st_w[i]), .lb_o(lb_w[i])
    );
  end

  assign plb_o = lb_w[0];
  assign llb_o = lb_w[1];
endmodule

// File: rtl/fdl_lb_chk.sv
module fdl_lb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] code_i,
  input logic       hit_w,
  input logic       rx_rd_i,
  input logic       alt_mode_i,
  input logic       ctrl_wr_i,
  input logic [3:0] ctrl_data_i,
  input logic [7:0] rx_code_o,
  input logic       irq_no,
  input logic       plb_o,
  input logic       llb_o,
  input logic [1:0] st_w
);
  // R3
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |=> !hit_w);
  // R5
  irq_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |=> !irq_no && rx_code_o[5:0] == $past(code_i));
  // R5
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && !hit_w |=> irq_no && rx_code_o == 8'h00);
  // R4
  rx_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_code_o[7:6] == 2'b00);
  // R6
  pl_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w && code_i == 6'b001010 |=> st_w[0]);
  // R7
  ll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w && code_i == 6'b011100 |=> !st_w[1]);
  // R8
  pl_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_data_i[0] |=> plb_o == $past(ctrl_data_i[1]));
  // R9
  alt_ll_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_mode_i |-> !llb_o);
endmodule

bind fdl_lb_detect fdl_lb_chk u_chk (
  .clk_i, .rst_ni, .code_i, .hit_w, .rx_rd_i, .alt_mode_i, .ctrl_wr_i,
  .ctrl_data_i, .rx_code_o, .irq_no, .plb_o, .llb_o, .st_w
);

// File: tb/sim_fdl_lb_detect.sv
module sim_fdl_lb_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] code_i = '0;
  logic       code_valid_i = 1'b0, alt_mode_i = 1'b0, ctrl_wr_i = 1'b0, rx_rd_i = 1'b0;
  logic [3:0] ctrl_data_i = '0;
  logic [7:0] rx_code_o;
  logic       irq_no, plb_o, llb_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fdl_lb_detect u0 (.*);

  // {req[3:0], valid, code[5:0], rd, irq_n, rx[5:0], plb, llb}
  function automatic logic [20:0] mk(int r, bit v, logic [5:0] c, bit rd,
                                     bit irqn, logic [5:0] rx, bit pl, bit ll);
    return {4'(r), v, c, rd, irqn, rx, pl, ll};
  endfunction

  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    mk(1, 1, 6'h0A, 0, 1, 6'h00, 0, 0), mk(1, 1, 6'h0A, 0, 1, 6'h00, 0, 0),
    mk(6, 1, 6'h0A, 0, 0, 6'h0A, 1, 0), mk(3, 1, 6'h0A, 0, 0, 6'h0A, 1, 0),
    mk(4, 0, 6'h00, 1, 1, 6'h00, 1, 0), mk(3, 1, 6'h0A, 0, 1, 6'h00, 1, 0),
    mk(1, 1, 6'h07, 0, 1, 6'h00, 1, 0), mk(1, 1, 6'h07, 0, 1, 6'h00, 1, 0),
    mk(1, 0, 6'h00, 0, 1, 6'h00, 1, 0), mk(7, 1, 6'h07, 0, 0, 6'h07, 1, 1),
    mk(5, 0, 6'h00, 1, 1, 6'h00, 1, 1), mk(2, 1, 6'h19, 0, 1, 6'h00, 1, 1),
    mk(2, 1, 6'h1C, 0, 1, 6'h00, 1, 1), mk(2, 1, 6'h19, 0, 1, 6'h00, 1, 1),
    mk(2, 1, 6'h19, 0, 1, 6'h00, 1, 1), mk(6, 1, 6'h19, 0, 0, 6'h19, 0, 1),
    mk(7, 1, 6'h1C, 0, 0, 6'h19, 0, 1), mk(7, 1, 6'h1C, 0, 0, 6'h19, 0, 1),
    mk(7, 1, 6'h1C, 0, 0, 6'h1C, 0, 0), mk(4, 0, 6'h00, 1, 1, 6'h00, 0, 0),
    mk(1, 1, 6'h2A, 0, 1, 6'h00, 0, 0), mk(1, 1, 6'h2A, 0, 1, 6'h00, 0, 0),
    mk(4, 1, 6'h2A, 0, 0, 6'h2A, 0, 0), mk(5, 0, 6'h00, 0, 0, 6'h2A, 0, 0),
    mk(4, 1, 6'h33, 1, 1, 6'h00, 0, 0), mk(1, 1, 6'h33, 0, 1, 6'h00, 0, 0),
    mk(4, 1, 6'h33, 1, 0, 6'h33, 0, 0), mk(5, 0, 6'h00, 1, 1, 6'h00, 0, 0)
  };

  function automatic string rtag(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, bit irqn, logic [7:0] rx, bit pl, bit ll);
    chk(req, "irq_no", 8'(irq_no), 8'(irqn));
    chk(req, "rx_code_o", rx_code_o, rx);
    chk(req, "plb_o", 8'(plb_o), 8'(pl));
    chk(req, "llb_o", 8'(llb_o), 8'(ll));
  endtask

  // drive, pass one rising edge, sample 2 units after it
  task automatic step(bit v, logic [5:0] c, bit rd, bit wr, logic [3:0] cd);
    code_valid_i = v; code_i = c; rx_rd_i = rd; ctrl_wr_i = wr; ctrl_data_i = cd;
    @(posedge clk_i); #2;
    code_valid_i = 1'b0; rx_rd_i = 1'b0; ctrl_wr_i = 1'b0;
  endtask

  task automatic send3(logic [5:0] c);
    for (int k = 0; k < 3; k++) step(1, c, 0, 0, 4'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R10 reset state
    repeat (2) @(posedge clk_i);
    #2;
    chk_all("R10", 1, 8'h00, 0, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      e = VEC[i];
      step(e[16], e[15:10], e[9], 0, 4'h0);
      chk_all(rtag(int'(e[20:17])), e[8], {2'b00, e[7:2]}, e[1], e[0]);
    end

    // R8 overrides: bit0 pl_en, bit1 pl_val, bit2 ll_en, bit3 ll_val
    step(0, 0, 0, 1, 4'b0011);
    chk("R8", "plb forced high", 8'(plb_o), 8'h1);
    step(0, 0, 0, 1, 4'b1100);
    chk("R8", "plb released", 8'(plb_o), 8'h0);
    chk("R8", "llb forced high", 8'(llb_o), 8'h1);
    step(0, 0, 0, 1, 4'b0100);
    send3(6'h07);
    chk("R8", "llb forced low over activate", 8'(llb_o), 8'h0);
    step(0, 0, 1, 1, 4'b0000);
    chk("R8", "llb state shows after release", 8'(llb_o), 8'h1);

    // R9 alternate mode
    alt_mode_i = 1'b1; #1;
    chk("R9", "llb low in alt mode", 8'(llb_o), 8'h0);
    step(0, 0, 0, 1, 4'b1100);
    chk("R9", "llb force ignored in alt mode", 8'(llb_o), 8'h0);
    step(0, 0, 0, 1, 4'b0000);
    send3(6'h1C);
    send3(6'h07);
    chk("R9", "llb after activate in alt mode", 8'(llb_o), 8'h0);
    chk("R9", "code still reported", rx_code_o, 8'h07);
    chk("R9", "irq still raised", 8'(irq_no), 8'h0);
    alt_mode_i = 1'b0; #1;
    chk("R9", "llb stays low after alt mode", 8'(llb_o), 8'h0);
    step(0, 0, 1, 0, 4'h0);

    // R10 reset mid-operation
    send3(6'h0A);
    step(0, 0, 0, 1, 4'b1100);
    chk("R10", "plb set before reset", 8'(plb_o), 8'h1);
    rst_ni = 1'b0; #3;
    chk_all("R10", 1, 8'h00, 0, 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 4'h0);
    chk("R10", "control cleared by reset", 8'(llb_o), 8'h0);

    finish_run();
  end
endmodule